// File: doc/BRIEF.md
# Memory Sleep-Mode Entry and Exit Controller

This block governs the low-power sleep state of a synchronous memory. A sleep request arrives on a pin that is not related to the memory clock. The block brings the request into the clock domain and steps through a fixed entry latency before it declares the memory asleep. When the request is released, it steps through a fixed exit latency and then a recovery window before it declares the memory ready again.

The block also checks how the surrounding logic uses it. An access still in flight when entry begins is flagged as invalid, because its completion cannot be guaranteed. A request made while any chip enable is active is a protocol error. Any chip enable or address strobe seen inside the post-exit recovery window is a violation. The protocol error and the violation flags stay set until reset. A retention output tells the array that its contents must be held.

Top module: `slp_ctrl`

## Requirements
- R1: After reset, ready=1 and asleep, retain, access_invalid, proto_err and recov_viol are all 0.
- R2: When sleep_req is raised (driven between clock edges), ready falls after the 3rd rising edge (two synchroniser stages plus one state update). Asleep rises after the 5th rising edge, which is a two-cycle entry.
- R3: When sleep_req is released, asleep falls after the 3rd rising edge. Ready returns after the 7th rising edge, which is a two-cycle exit followed by a two-cycle recovery window.
- R4: Ready and asleep are never high together. Ready is high only when awake, and asleep is high only in the sleep state.
- R5: Retain is high while asleep and during the two exit cycles, and low while awake, entering and in recovery.
- R6: If access_pending is high on the edge where entry begins, access_invalid is high for exactly one cycle. Otherwise it stays low.
- R7: If any chip_en bit is high on the edge where entry begins, proto_err is set. It stays set until reset.
- R8: Any chip_en or addr_stb bit high in a recovery-window cycle sets recov_viol. It stays set until reset, and reset clears it.
- R9: Chip enables or strobes while awake or during the exit cycles do not set recov_viol.
- R10: If sleep_req drops while entry is in progress, entry still completes to the sleep state, and a normal exit and recovery follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | Asynchronous sleep request, high = sleep |
| chip_en | input | 3 | Active-high chip enables from the access side |
| addr_stb | input | 2 | Active-high address strobes from the access side |
| access_pending | input | 1 | High while an access is in flight |
| ready | output | 1 | Memory awake and accepting accesses |
| asleep | output | 1 | Memory in the sleep state |
| retain | output | 1 | Array must hold its contents |
| access_invalid | output | 1 | One-cycle pulse: an in-flight access was dropped at entry |
| proto_err | output | 1 | Sticky: sleep requested while selected |
| recov_viol | output | 1 | Sticky: select or strobe during recovery |

## Verification
The hardest case is a request withdrawn during entry. The release must land inside the two-cycle entry window after passing through the synchroniser. The bench raises the request, waits exactly until the state has just left awake, and drops it on that same half-cycle. It then checks that the sleep state lasts one cycle before exit begins. The recovery violation likewise depends on placing a strobe in a two-cycle window counted from the release. The bench counts falling edges from the release so the strobe lands inside that window, and it places enables in the exit cycles just before the window to show they are tolerated.

// File: rtl/slp_pkg.sv
package slp_pkg;

  typedef enum logic [2:0] {
    ST_AWAKE = 3'd0,
    ST_ENTER = 3'd1,
    ST_SLEEP = 3'd2,
    ST_EXIT  = 3'd3,
    ST_RECOV = 3'd4
  } slp_state_e;

  // Next-state rule; 'done' means the current timed phase has expired.
  function automatic slp_state_e slp_next(slp_state_e cur, logic req, logic done);
    slp_state_e n;
    n = cur;
    case (cur)
      ST_AWAKE: if (req)  n = ST_ENTER;
      ST_ENTER: if (done) n = ST_SLEEP;
      ST_SLEEP: if (!req) n = ST_EXIT;
      ST_EXIT:  if (done) n = ST_RECOV;
      ST_RECOV: if (done) n = ST_AWAKE;
      default:            n = ST_AWAKE;
    endcase
    return n;
  endfunction

  function automatic int unsigned slp_max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/slp_sync.sv
module slp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d_async;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/slp_fsm.sv
module slp_fsm
  import slp_pkg::*;
#(
  parameter int unsigned ENTRY_CYC = 2,
  parameter int unsigned EXIT_CYC  = 2,
  parameter int unsigned REC_CYC   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_s,
  output slp_state_e state_o,
  output logic       enter_start,
  output logic       in_recov,
  output logic       ready_o,
  output logic       asleep_o,
  output logic       retain_o
);
  localparam int unsigned MAXLAT = slp_max3(ENTRY_CYC, EXIT_CYC, REC_CYC);
  localparam int unsigned CW     = (MAXLAT > 1) ? $clog2(MAXLAT) : 1;

  slp_state_e    state, nxt;
  logic [CW-1:0] cnt;
  logic          cnt_zero;

  assign cnt_zero = (cnt == '0);

  always_comb nxt = slp_next(state, req_s, cnt_zero);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_AWAKE;
      cnt   <= '0;
    end else begin
      state <= nxt;
      if (nxt != state) begin
        case (nxt)
          ST_ENTER: cnt <= CW'(ENTRY_CYC - 1);
          ST_EXIT:  cnt <= CW'(EXIT_CYC - 1);
          ST_RECOV: cnt <= CW'(REC_CYC - 1);
          default:  cnt <= '0;
        endcase
      end else if (!cnt_zero) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign state_o     = state;
  assign enter_start = (state == ST_AWAKE) && req_s;
  assign in_recov    = (state == ST_RECOV);
  assign ready_o     = (state == ST_AWAKE);
  assign asleep_o    = (state == ST_SLEEP);
  assign retain_o    = (state == ST_SLEEP) || (state == ST_EXIT);

  // R4: ready and asleep never overlap
  a_r4_ready_asleep_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready_o && asleep_o));
  // R2: no departure from awake without a synchronised request
  a_r2_stay_awake: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_AWAKE && !req_s) |=> (state == ST_AWAKE));
  // R10: entry always completes into sleep, never back to awake
  a_r10_entry_completes: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ENTER) |=> (state == ST_ENTER || state == ST_SLEEP));
  // R3: released request in sleep starts the exit next cycle
  a_r3_exit_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLEEP && !req_s) |=> (state == ST_EXIT));
  // R5: asleep implies retention
  a_r5_retain_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    asleep_o |-> retain_o);
endmodule

// File: rtl/slp_guard.sv
module slp_guard #(
  parameter int unsigned NUM_CE  = 3,
  parameter int unsigned NUM_STB = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enter_start,
  input  logic               in_recov,
  input  logic [NUM_CE-1:0]  ce,
  input  logic [NUM_STB-1:0] stb,
  input  logic               pending,
  output logic               invalid_o,
  output logic               proto_o,
  output logic               viol_o
);
  logic any_sel, any_stb, recov_hit;

  assign any_sel   = |ce;
  assign any_stb   = |stb;
  assign recov_hit = in_recov && (any_sel || any_stb);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      invalid_o <= 1'b0;
      proto_o   <= 1'b0;
      viol_o    <= 1'b0;
    end else begin
      invalid_o <= enter_start && pending;
      if (enter_start && any_sel) proto_o <= 1'b1;
      if (recov_hit)              viol_o  <= 1'b1;
    end
  end

  // R8: violation is sticky
  a_r8_viol_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    viol_o |=> viol_o);
  // R8: recovery access always raises the flag
  a_r8_viol_raise: assert property (@(posedge clk) disable iff (!rst_n)
    recov_hit |=> viol_o);
  // R7: protocol error is sticky
  a_r7_proto_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    proto_o |=> proto_o);
  // R6: invalid pulse lasts one cycle
  a_r6_invalid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_o |=> !invalid_o);
endmodule

// File: rtl/slp_ctrl.sv
module slp_ctrl
  import slp_pkg::*;
#(
  parameter int unsigned NUM_CE      = 3,
  parameter int unsigned NUM_STB     = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ENTRY_CYC   = 2,
  parameter int unsigned EXIT_CYC    = 2,
  parameter int unsigned REC_CYC     = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sleep_req,
  input  logic [NUM_CE-1:0]  chip_en,
  input  logic [NUM_STB-1:0] addr_stb,
  input  logic               access_pending,
  output logic               ready,
  output logic               asleep,
  output logic               retain,
  output logic               access_invalid,
  output logic               proto_err,
  output logic               recov_viol
);
  logic       req_s;
  slp_state_e state;
  logic       enter_start;
  logic       in_recov;

  slp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (sleep_req),
    .q_sync  (req_s)
  );

  slp_fsm #(
    .ENTRY_CYC (ENTRY_CYC),
    .EXIT_CYC  (EXIT_CYC),
    .REC_CYC   (REC_CYC)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_s       (req_s),
    .state_o     (state),
    .enter_start (enter_start),
    .in_recov    (in_recov),
    .ready_o     (ready),
    .asleep_o    (asleep),
    .retain_o    (retain)
  );

  slp_guard #(.NUM_CE(NUM_CE), .NUM_STB(NUM_STB)) u_guard (
    .clk         (clk),
    .rst_n       (rst_n),
    .enter_start (enter_start),
    .in_recov    (in_recov),
    .ce          (chip_en),
    .stb         (addr_stb),
    .pending     (access_pending),
    .invalid_o   (access_invalid),
    .proto_o     (proto_err),
    .viol_o      (recov_viol)
  );

  // R9: the violation flag can only rise out of a recovery cycle
  a_r9_viol_only_recov: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(recov_viol) |-> $past(state) == ST_RECOV);
endmodule

// File: tb/tb_slp_ctrl.sv
`timescale 1ns/1ps
module tb_slp_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sleep_req;
  logic [2:0] chip_en;
  logic [1:0] addr_stb;
  logic       access_pending;
  logic ready, asleep, retain, access_invalid, proto_err, recov_viol;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  slp_ctrl dut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .chip_en(chip_en),
    .addr_stb(addr_stb), .access_pending(access_pending), .ready(ready),
    .asleep(asleep), .retain(retain), .access_invalid(access_invalid),
    .proto_err(proto_err), .recov_viol(recov_viol)
  );

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", what, act, exp);
    end
  endtask

  task automatic nwait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sleep_req = 1'b0; chip_en = '0; addr_stb = '0; access_pending = 1'b0;
    nwait(2);
    rst_n = 1'b1;
    nwait(1);
  endtask

  task automatic go_sleep();
    sleep_req = 1'b1;
    nwait(5);
  endtask

  task automatic t_reset();
    do_reset();
    chk(ready, 1'b1, "R1 ready");
    chk(asleep, 1'b0, "R1 asleep");
    chk(retain, 1'b0, "R1 retain");
    chk(access_invalid, 1'b0, "R1 invalid");
    chk(proto_err, 1'b0, "R1 proto");
    chk(recov_viol, 1'b0, "R1 viol");
  endtask

  task automatic t_entry_exit();
    do_reset();
    sleep_req = 1'b1;
    nwait(2);
    chk(ready, 1'b1, "R2 ready still high after 2 edges");
    nwait(1);
    chk(ready, 1'b0, "R2 ready low after 3 edges");
    chk(asleep, 1'b0, "R2 not asleep while entering");
    chk(retain, 1'b0, "R5 no retain while entering");
    chk(access_invalid, 1'b0, "R6 no invalid without pending");
    nwait(1);
    chk(asleep, 1'b0, "R2 asleep low after 4 edges");
    nwait(1);
    chk(asleep, 1'b1, "R2 asleep after 5 edges");
    chk(ready, 1'b0, "R4 ready low while asleep");
    chk(retain, 1'b1, "R5 retain while asleep");
    nwait(3);
    chk(asleep, 1'b1, "R2 holds asleep");
    sleep_req = 1'b0;
    nwait(2);
    chk(asleep, 1'b1, "R3 asleep after 2 edges");
    nwait(1);
    chk(asleep, 1'b0, "R3 asleep low after 3 edges");
    chk(retain, 1'b1, "R5 retain in exit");
    chk(ready, 1'b0, "R4 not ready in exit");
    nwait(2);
    chk(retain, 1'b0, "R5 retain low in recovery");
    chk(ready, 1'b0, "R3 not ready in recovery");
    nwait(1);
    chk(ready, 1'b0, "R3 not ready after 6 edges");
    nwait(1);
    chk(ready, 1'b1, "R3 ready after 7 edges");
    chk(recov_viol, 1'b0, "R8 no violation on clean wake");
  endtask

  task automatic t_pending();
    do_reset();
    access_pending = 1'b1;
    sleep_req = 1'b1;
    nwait(3);
    chk(access_invalid, 1'b1, "R6 invalid at entry start");
    nwait(1);
    chk(access_invalid, 1'b0, "R6 invalid one cycle only");
    access_pending = 1'b0;
  endtask

  task automatic t_proto();
    do_reset();
    chip_en = 3'b100;
    sleep_req = 1'b1;
    nwait(3);
    chk(proto_err, 1'b1, "R7 proto set");
    chip_en = '0;
    nwait(4);
    sleep_req = 1'b0;
    nwait(8);
    chk(ready, 1'b1, "R7 awake again");
    chk(proto_err, 1'b1, "R7 proto sticky");
    do_reset();
    chk(proto_err, 1'b0, "R7 reset clears proto");
  endtask

  task automatic t_violation();
    do_reset();
    go_sleep();
    sleep_req = 1'b0;
    nwait(5);
    addr_stb = 2'b10;
    nwait(1);
    chk(recov_viol, 1'b1, "R8 strobe in recovery flagged");
    addr_stb = '0;
    nwait(5);
    chk(recov_viol, 1'b1, "R8 violation sticky");
    chk(ready, 1'b1, "R8 awake after recovery");
    do_reset();
    chk(recov_viol, 1'b0, "R8 reset clears violation");
    go_sleep();
    sleep_req = 1'b0;
    nwait(6);
    chip_en = 3'b001;
    nwait(1);
    chk(recov_viol, 1'b1, "R8 enable in last recovery cycle flagged");
    chip_en = '0;
  endtask

  task automatic t_no_viol();
    do_reset();
    chip_en = 3'b111; addr_stb = 2'b11;
    nwait(3);
    chk(recov_viol, 1'b0, "R9 awake selects ignored");
    chip_en = '0; addr_stb = '0;
    go_sleep();
    sleep_req = 1'b0;
    nwait(3);
    chip_en = 3'b010; addr_stb = 2'b01;
    nwait(2);
    chip_en = '0; addr_stb = '0;
    nwait(2);
    chk(ready, 1'b1, "R9 ready after exit");
    chk(recov_viol, 1'b0, "R9 exit-phase selects ignored");
  endtask

  task automatic t_abort();
    do_reset();
    sleep_req = 1'b1;
    nwait(3);
    chk(ready, 1'b0, "R10 entry started");
    sleep_req = 1'b0;
    nwait(2);
    chk(asleep, 1'b1, "R10 entry completes");
    nwait(1);
    chk(asleep, 1'b0, "R10 exit follows");
    chk(retain, 1'b1, "R10 retain in exit");
    nwait(3);
    chk(ready, 1'b0, "R10 still recovering");
    nwait(1);
    chk(ready, 1'b1, "R10 ready after normal exit");
  endtask

  initial begin
    #(200000 * 5.0);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sleep_req = 1'b0; chip_en = '0; addr_stb = '0; access_pending = 1'b0;
    t_reset();
    t_entry_exit();
    t_pending();
    t_proto();
    t_violation();
    t_no_viol();
    t_abort();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule